// File: doc/BRIEF.md
# Presettable Bi-Quinary Decade Counter

A four-bit decade counter made of two sections that can be chained in either order. A divide-by-two section drives bit 0 of the output. A divide-by-five section drives bits 3 to 1. Each section advances on a falling edge of its own external clock input.

When bit 0 feeds the divide-by-five section, the four bits count in plain binary-coded decimal from 0 to 9. When bit 3 feeds the divide-by-two section, bit 0 becomes a square wave at one tenth of the rate of the feeding clock. The cascade direction is chosen at run time by a mode input.

An active-low clear forces the output to zero. An active-low load copies four data bits into the counter. While the load is held, the output follows the data, and when the load is released the last value stays, so the block can also serve as a 4-bit latch. The external clock inputs are synchronised to one system clock and their falling edges are detected there, so the whole block runs on that one clock.

Top module: `bq_decade_counter`

## Requirements
- R1: While `clr_ni` is low, `count_o` reads 0 in the same system cycle. This holds even when `load_ni` is low. The stored value is 0 after any rising `clk_i` edge at which `clr_ni` was low.
- R2: While `clr_ni` is high and `load_ni` is low, `count_o` equals `data_i` in the same cycle. After `load_ni` returns high, the last loaded value is held until a count occurs.
- R3: A falling edge on an external clock input takes effect at the second rising `clk_i` edge after the first edge that samples the input low. A count never happens earlier.
- R4: Bits [3:1] of `count_o` (bit 3 most significant) step through 0, 1, 2, 3, 4 and then back to 0, one step per advance of the divide-by-five section.
- R5: If a load leaves bits [3:1] at 5, 6 or 7, the next advance takes them to 2, 2 or 0 respectively.
- R6: With `mode_i` = 0, bit 0 toggles on each falling edge of `clk_a_i`. Bit 0 falling advances bits [3:1], so the value counts 0 through 9 and then wraps to 0. In this mode `clk_b_i` has no effect.
- R7: With `mode_i` = 1, bits [3:1] advance on each falling edge of `clk_b_i`. Bit 3 falling toggles bit 0, so over ten `clk_b_i` edges bit 0 is high for five of them. In this mode `clk_a_i` has no effect.
- R8: Rising edges on `clk_a_i` or `clk_b_i` never change the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low system reset |
| clr_ni | input | 1 | Active-low level clear of the counter |
| load_ni | input | 1 | Active-low level parallel load |
| mode_i | input | 1 | Cascade select: 0 BCD, 1 bi-quinary |
| clk_a_i | input | 1 | Falling-edge clock of the divide-by-two section |
| clk_b_i | input | 1 | Falling-edge clock of the divide-by-five section |
| data_i | input | 4 | Parallel load data |
| count_o | output | 4 | Counter value; bit 0 from divide-by-two, bits 3:1 from divide-by-five |

## Verification
The bench targets the wrap from 9 to 0 in BCD mode. A design with a wrong cascade would go on to 10, or would skip the tens step. It loads the three unused divide-by-five states and advances once. A design without recovery would lock up or climb to an out-of-range value. It checks the exact cycle in which a count lands after a synchronised falling edge; an off-by-one pipeline shows up as an early or late step. It also pulses the clock input that the active mode does not use, applies rising edges alone, and asserts clear together with load. A leaky cascade mux, a counter that fires on both edges, or reversed priority between clear and load each changes the output there.

// File: rtl/bqc_pkg.sv
package bqc_pkg;
  typedef enum logic {
    CASC_BCD = 1'b0,
    CASC_BIQ = 1'b1
  } casc_e;

  localparam int unsigned QUI_W = 3;

  function automatic logic [QUI_W-1:0] qui_next(input logic [QUI_W-1:0] s);
    logic [QUI_W-1:0] n;
    case (s)
      3'd0: n = 3'd1;
      3'd1: n = 3'd2;
      3'd2: n = 3'd3;
      3'd3: n = 3'd4;
      3'd4: n = 3'd0;
      3'd5: n = 3'd2;
      3'd6: n = 3'd2;
      default: n = 3'd0;
    endcase
    return n;
  endfunction
endpackage

// File: rtl/bqc_fall_detect.sv
module bqc_fall_detect #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sig_i,
  output logic fall_o
);
  localparam int unsigned LEN = SYNC_STAGES + 1;

  logic [LEN-1:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '1;
    else         sh_q <= {sh_q[LEN-2:0], sig_i};
  end

  // oldest synced sample high, next one low
  assign fall_o = sh_q[LEN-1] & ~sh_q[LEN-2];
endmodule

// File: rtl/bqc_div2.sv
module bqc_div2 (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_ni,
  input  logic load_ni,
  input  logic ld_i,
  input  logic adv_i,
  output logic q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       q_o <= 1'b0;
    else if (!clr_ni)  q_o <= 1'b0;
    else if (!load_ni) q_o <= ld_i;
    else if (adv_i)    q_o <= ~q_o;
  end
endmodule

// File: rtl/bqc_div5.sv
module bqc_div5
  import bqc_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_ni,
  input  logic             load_ni,
  input  logic [QUI_W-1:0] ld_i,
  input  logic             adv_i,
  output logic [QUI_W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       q_o <= '0;
    else if (!clr_ni)  q_o <= '0;
    else if (!load_ni) q_o <= ld_i;
    else if (adv_i)    q_o <= qui_next(q_o);
  end
endmodule

// File: rtl/bq_decade_counter.sv
module bq_decade_counter
  import bqc_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       clr_ni,
  input  logic       load_ni,
  input  logic       mode_i,
  input  logic       clk_a_i,
  input  logic       clk_b_i,
  input  logic [3:0] data_i,
  output logic [3:0] count_o
);
  localparam int unsigned N_EXT = 2;

  logic [N_EXT-1:0] ext_clk;
  logic [N_EXT-1:0] ext_fall;
  logic             q0;
  logic [QUI_W-1:0] qq;
  logic             adv2, adv5;

  assign ext_clk = {clk_b_i, clk_a_i};

  for (genvar g = 0; g < N_EXT; g++) begin : g_sync
    bqc_fall_detect #(.SYNC_STAGES(SYNC_STAGES)) u_fd (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .sig_i (ext_clk[g]),
      .fall_o(ext_fall[g])
    );
  end

  // cascade resolved in the same cycle: downstream advances when upstream leaves its top state
  always_comb begin
    if (casc_e'(mode_i) == CASC_BIQ) begin
      adv5 = ext_fall[1];
      adv2 = ext_fall[1] & qq[QUI_W-1];
    end else begin
      adv2 = ext_fall[0];
      adv5 = ext_fall[0] & q0;
    end
  end

  bqc_div2 u_div2 (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_ni (clr_ni),
    .load_ni(load_ni),
    .ld_i   (data_i[0]),
    .adv_i  (adv2),
    .q_o    (q0)
  );

  bqc_div5 u_div5 (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_ni (clr_ni),
    .load_ni(load_ni),
    .ld_i   (data_i[3:1]),
    .adv_i  (adv5),
    .q_o    (qq)
  );

  // level clear and load bypass the registers so they act in the same cycle
  always_comb begin
    if (!clr_ni)       count_o = '0;
    else if (!load_ni) count_o = data_i;
    else               count_o = {qq, q0};
  end
endmodule

// File: rtl/bq_decade_counter_chk.sv
module bq_decade_counter_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       clr_ni,
  input logic       load_ni,
  input logic       mode_i,
  input logic [3:0] data_i,
  input logic [3:0] count_o
);
  function automatic logic [2:0] step5(input logic [2:0] v);
    if (v < 3'd4)       return v + 3'd1;
    else if (v == 3'd4) return 3'd0;
    else if (v == 3'd7) return 3'd0;
    else                return 3'd2;
  endfunction

  logic run_now, run_prev;
  assign run_now = clr_ni & load_ni;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) run_prev <= 1'b0;
    else         run_prev <= run_now;
  end

  // R1
  a_r1_clear_stored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(!clr_ni) && clr_ni && load_ni) |-> count_o == 4'd0);

  // R2
  a_r2_latch_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(clr_ni) && $past(!load_ni) && run_now) |-> count_o == $past(data_i));

  // R4
  a_r4_quinary_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_prev && run_now && count_o[3:1] != $past(count_o[3:1]))
      |-> count_o[3:1] == step5($past(count_o[3:1])));

  // R5
  a_r5_back_in_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_prev && run_now && count_o[3:1] != $past(count_o[3:1])) |-> count_o[3:1] <= 3'd4);

  // R6
  a_r6_bcd_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_prev && run_now && !mode_i && $stable(mode_i) && $past(count_o) <= 4'd9)
      |-> count_o <= 4'd9);
endmodule

bind bq_decade_counter bq_decade_counter_chk u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .clr_ni (clr_ni),
  .load_ni(load_ni),
  .mode_i (mode_i),
  .data_i (data_i),
  .count_o(count_o)
);

// File: tb/bq_decade_counter_test.sv
`timescale 1ns/1ps
module bq_decade_counter_test;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       clr_ni = 1'b1;
  logic       load_ni = 1'b1;
  logic       mode_i = 1'b0;
  logic       clk_a_i = 1'b1;
  logic       clk_b_i = 1'b1;
  logic [3:0] data_i = 4'd0;
  logic [3:0] count_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  string req = "R1";

  // reference state and sampled input history (a: div-by-2 clock, b: div-by-5 clock)
  int ms = 0;
  int ha1 = 1, ha2 = 1, ha3 = 1;
  int hb1 = 1, hb2 = 1, hb3 = 1;

  always #2.5 clk = ~clk;

  bq_decade_counter uut (
    .clk_i  (clk),
    .rst_ni (rst_ni),
    .clr_ni (clr_ni),
    .load_ni(load_ni),
    .mode_i (mode_i),
    .clk_a_i(clk_a_i),
    .clk_b_i(clk_b_i),
    .data_i (data_i),
    .count_o(count_o)
  );

  function automatic int adv5(int c);
    int v, n;
    v = c / 2;
    if (v < 4)       n = v + 1;
    else if (v == 4) n = 0;
    else if (v == 7) n = 0;
    else             n = 2;
    return n * 2 + (c % 2);
  endfunction

  task automatic check(input int got, input int exp, input string r);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: count_o=%0d expected %0d at %0t", r, got, exp, $time);
    end
  endtask

  function automatic int expect_out();
    if (!clr_ni)  return 0;
    if (!load_ni) return int'(data_i);
    return ms;
  endfunction

  task automatic step();
    int fa, fb, q3;
    @(posedge clk);
    fa = (ha3 == 1 && ha2 == 0) ? 1 : 0;
    fb = (hb3 == 1 && hb2 == 0) ? 1 : 0;
    if (!rst_ni) begin
      ms = 0;
    end else if (!clr_ni) begin
      ms = 0;
    end else if (!load_ni) begin
      ms = int'(data_i);
    end else if (mode_i == 1'b0) begin
      if (fa == 1) begin
        if (ms % 2 == 1) ms = adv5(ms) - 1;
        else             ms = ms + 1;
      end
    end else begin
      if (fb == 1) begin
        q3 = ms / 8;
        ms = adv5(ms);
        if (q3 == 1) ms = (ms % 2 == 1) ? ms - 1 : ms + 1;
      end
    end
    ha3 = ha2; ha2 = ha1; ha1 = rst_ni ? int'(clk_a_i) : 1;
    hb3 = hb2; hb2 = hb1; hb1 = rst_ni ? int'(clk_b_i) : 1;
    #1;
    check(int'(count_o), expect_out(), req);
  endtask

  task automatic steps(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic pulse_a();
    clk_a_i = 1'b0; steps(2);
    clk_a_i = 1'b1; steps(2);
  endtask

  task automatic pulse_b();
    clk_b_i = 1'b0; steps(2);
    clk_b_i = 1'b1; steps(2);
  endtask

  task automatic load_val(input logic [3:0] v);
    data_i = v; load_ni = 1'b0; step();
    load_ni = 1'b1; step();
  endtask

  initial begin
    int hi;
    // R1 reset state
    steps(3);
    check(int'(count_o), 0, "R1");
    rst_ni = 1'b1;
    steps(2);

    // R6 BCD count and wrap
    req = "R6";
    mode_i = 1'b0;
    for (int i = 1; i <= 9; i++) pulse_a();
    check(int'(count_o), 9, "R6");
    pulse_a();
    check(int'(count_o), 0, "R6");
    for (int i = 0; i < 3; i++) pulse_b();
    check(int'(count_o), 0, "R6");

    // R3 latency from falling edge
    req = "R3";
    clk_a_i = 1'b0;
    step(); check(int'(count_o), 0, "R3");
    step(); check(int'(count_o), 0, "R3");
    step(); check(int'(count_o), 1, "R3");
    // R8 rising edge alone does nothing
    req = "R8";
    clk_a_i = 1'b1;
    steps(5);
    check(int'(count_o), 1, "R8");

    // R2 transparent load then latch hold
    req = "R2";
    data_i = 4'd6; load_ni = 1'b0;
    #1 check(int'(count_o), 6, "R2");
    step();
    data_i = 4'd3;
    #1 check(int'(count_o), 3, "R2");
    step();
    load_ni = 1'b1; data_i = 4'd12;
    steps(4);
    check(int'(count_o), 3, "R2");

    // R1 clear beats load
    req = "R1";
    clr_ni = 1'b0; load_ni = 1'b0; data_i = 4'd15;
    #1 check(int'(count_o), 0, "R1");
    steps(2);
    load_ni = 1'b1; step();
    clr_ni = 1'b1; step();
    check(int'(count_o), 0, "R1");

    // R4 / R7 bi-quinary mode
    req = "R7";
    mode_i = 1'b1;
    hi = 0;
    for (int i = 1; i <= 10; i++) begin
      pulse_b();
      if (i <= 4) check(int'(count_o) / 2, i, "R4");
      if (count_o[0]) hi++;
    end
    check(hi, 5, "R7");
    check(int'(count_o), 0, "R7");
    for (int i = 0; i < 3; i++) pulse_a();
    check(int'(count_o), 0, "R7");

    // R5 recovery from unused quinary states
    req = "R5";
    load_val(4'd10); pulse_b(); check(int'(count_o), 5, "R5");
    load_val(4'd12); pulse_b(); check(int'(count_o), 5, "R5");
    load_val(4'd14); pulse_b(); check(int'(count_o), 1, "R5");
    mode_i = 1'b0;
    load_val(4'd11); pulse_a(); check(int'(count_o), 4, "R5");

    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #200000;
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule